// File: doc/BRIEF.md
# Byte-Lane Shift, Mask, Extract and Insert Unit

This block is a 64-bit datapath unit that performs word shifts and byte-lane manipulation. A 7-bit function code selects the operation. Operand A supplies the data. The low bits of operand B supply the shift amount, the byte offset or the byte-select mask. The result is captured in a register one clock after a valid request, and it is flagged illegal when the code is not one the unit implements.

Software builds unaligned loads and stores from these operations. A field that straddles two aligned quadwords is handled as follows:
- The low-form operations cover the part of the field in the first quadword.
- The high-form operations cover the part that spills into the following quadword.
- Zap and zap-not clear or keep whole bytes under an 8-bit mask when the pieces are merged.

The byte offset is always B[2:0], and shift positions are multiples of eight bits. The size field is func[5:4], where 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes. This encoding applies to every mask, extract and insert code.

Top module: `bms_unit`

## Requirements
- R1: Shifts use B[5:0] as the amount and ignore higher bits of B. Code 0x39 shifts A left with zero fill, 0x34 shifts right with zero fill, and 0x3c shifts right with copies of A[63].
- R2: Mask-low codes 0x02, 0x12, 0x22 and 0x32 clear a 1-, 2-, 4- or 8-byte field of A that starts at bit 8*B[2:0]. Field bytes that would lie above bit 63 are not cleared.
- R3: Mask-high codes 0x52, 0x62 and 0x72 (2, 4 or 8 bytes) return A unchanged when B[2:0] is 0. Otherwise they clear the bits of the all-ones field mask shifted right by 64 − 8*B[2:0].
- R4: Extract-low codes 0x06, 0x16, 0x26 and 0x36 shift A right by 8*B[2:0] and keep the low 1, 2, 4 or 8 bytes.
- R5: Extract-high codes 0x5a, 0x6a and 0x7a shift A left by (64 − 8*B[2:0]) mod 64 and keep the low 2, 4 or 8 bytes. An offset of 0 therefore applies no shift.
- R6: Insert-low codes 0x0b, 0x1b, 0x2b and 0x3b take the low 1, 2, 4 or 8 bytes of A and shift them left by 8*B[2:0], discarding bits above bit 63.
- R7: Insert-high codes 0x57, 0x67 and 0x77 return zero when B[2:0] is 0. Otherwise they shift the low 2-, 4- or 8-byte field of A right by 64 − 8*B[2:0].
- R8: Code 0x30 clears byte i of A for each set bit i of B[7:0], and code 0x31 clears byte i for each clear bit. B bits above 7 have no effect.
- R9: A request accepted on a clock edge with in_valid_i high appears on result_o with out_valid_o high after that edge. out_valid_o is low after any edge where in_valid_i was low.
- R10: Any function code not listed in R1–R8 gives a result of zero with illegal_o high. illegal_o is low for every listed code.
- R11: While rst_ni is low, result_o, out_valid_o and illegal_o are all zero.
- R12: When in_valid_i is low, result_o keeps its previous value whatever func_i, a_i and b_i carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Request present this cycle |
| func_i | input | 7 | Function code |
| a_i | input | 64 | Data operand |
| b_i | input | 64 | Amount, offset or byte-select operand |
| out_valid_o | output | 1 | Result register holds a fresh result |
| result_o | output | 64 | Registered result |
| illegal_o | output | 1 | Last accepted code was not implemented |

## Verification
The bench builds the unit with its default of eight byte lanes, which gives the 64-bit datapath. With that default the 3-bit offset spans every lane, including offset 0 and offset 7. Those two values bring in the zero-offset special cases of the high forms and the case where a low-form field is cut off at bit 63. The vectors also cover all three shift kinds at amounts 0, 4 and 63 and full and partial zap masks. The directed part covers hold-while-idle, illegal-code recovery and a reset taken after traffic.

// File: rtl/bms_pkg.sv
package bms_pkg;

    localparam int FUNC_W = 7;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_SLL,
        OP_SRL,
        OP_SRA,
        OP_MSKL,
        OP_MSKH,
        OP_EXTL,
        OP_EXTH,
        OP_INSL,
        OP_INSH,
        OP_ZAP,
        OP_ZAPN
    } bms_op_e;

    // Field size in bytes is 1 << size.
    typedef enum logic [1:0] {
        SZ_BYTE,
        SZ_WORD,
        SZ_LONG,
        SZ_QUAD
    } bms_size_e;

endpackage

// File: rtl/bms_decode.sv
module bms_decode
    import bms_pkg::*;
(
    input  logic [FUNC_W-1:0] func_i,
    output bms_op_e           op_o,
    output bms_size_e         size_o,
    output logic              bad_o
);

    always_comb begin
        op_o   = OP_NONE;
        size_o = bms_size_e'(func_i[5:4]);
        bad_o  = 1'b0;
        unique case (func_i)
            7'h39:                      op_o = OP_SLL;
            7'h34:                      op_o = OP_SRL;
            7'h3c:                      op_o = OP_SRA;
            7'h02, 7'h12, 7'h22, 7'h32: op_o = OP_MSKL;
            7'h52, 7'h62, 7'h72:        op_o = OP_MSKH;
            7'h06, 7'h16, 7'h26, 7'h36: op_o = OP_EXTL;
            7'h5a, 7'h6a, 7'h7a:        op_o = OP_EXTH;
            7'h0b, 7'h1b, 7'h2b, 7'h3b: op_o = OP_INSL;
            7'h57, 7'h67, 7'h77:        op_o = OP_INSH;
            7'h30:                      op_o = OP_ZAP;
            7'h31:                      op_o = OP_ZAPN;
            default:                    bad_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/bms_lanes.sv
module bms_lanes
    import bms_pkg::*;
#(
    parameter  int LANES   = 8,
    localparam int DATA_W  = 8 * LANES,
    localparam int OFS_W   = $clog2(LANES),
    localparam int SHAMT_W = $clog2(DATA_W)
) (
    input  bms_op_e           op_i,
    input  bms_size_e         size_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] y_o
);

    logic [DATA_W-1:0]  fmask;     // all-ones over the selected field size
    logic [DATA_W-1:0]  zkeep;     // bytes kept by zap / zap-not
    logic [OFS_W-1:0]   ofs;
    logic [SHAMT_W-1:0] sh;        // 8 * offset
    logic [SHAMT_W-1:0] hsh;       // (width - 8 * offset) mod width
    logic [SHAMT_W-1:0] amt;
    logic               ofs_zero;
    logic               unused_bhi;

    assign ofs        = b_i[OFS_W-1:0];
    assign sh         = SHAMT_W'({ofs, 3'b000});
    assign hsh        = SHAMT_W'(0) - sh;
    assign amt        = b_i[SHAMT_W-1:0];
    assign ofs_zero   = (ofs == '0);
    assign unused_bhi = ^b_i[DATA_W-1:LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign fmask[8*g +: 8] = (32'(g) < (32'd1 << size_i)) ? 8'hFF : 8'h00;
        assign zkeep[8*g +: 8] = {8{(op_i == OP_ZAPN) ? b_i[g] : ~b_i[g]}};
    end

    always_comb begin
        unique case (op_i)
            OP_SLL:  y_o = a_i << amt;
            OP_SRL:  y_o = a_i >> amt;
            OP_SRA:  y_o = DATA_W'($signed(a_i) >>> amt);
            OP_MSKL: y_o = a_i & ~(fmask << sh);
            OP_MSKH: y_o = ofs_zero ? a_i : (a_i & ~(fmask >> hsh));
            OP_EXTL: y_o = (a_i >> sh) & fmask;
            OP_EXTH: y_o = (a_i << hsh) & fmask;
            OP_INSL: y_o = (a_i & fmask) << sh;
            OP_INSH: y_o = ofs_zero ? '0 : ((a_i & fmask) >> hsh);
            OP_ZAP,
            OP_ZAPN: y_o = a_i & zkeep;
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/bms_unit.sv
module bms_unit
    import bms_pkg::*;
#(
    parameter  int LANES  = 8,
    localparam int DATA_W = 8 * LANES
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              in_valid_i,
    input  logic [6:0]        func_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] result_o,
    output logic              illegal_o
);

    bms_op_e           op;
    bms_size_e         size;
    logic              bad;
    logic [DATA_W-1:0] lane_y;

    logic              valid_q, valid_d;
    logic              illegal_q, illegal_d;
    logic [DATA_W-1:0] result_q, result_d;

    bms_decode u_decode (
        .func_i (func_i),
        .op_o   (op),
        .size_o (size),
        .bad_o  (bad)
    );

    bms_lanes #(.LANES(LANES)) u_lanes (
        .op_i   (op),
        .size_i (size),
        .a_i    (a_i),
        .b_i    (b_i),
        .y_o    (lane_y)
    );

    always_comb begin
        valid_d   = in_valid_i;
        illegal_d = in_valid_i & bad;
        result_d  = result_q;
        if (in_valid_i) begin
            result_d = bad ? '0 : lane_y;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            valid_q   <= 1'b0;
            illegal_q <= 1'b0;
            result_q  <= '0;
        end else begin
            valid_q   <= valid_d;
            illegal_q <= illegal_d;
            result_q  <= result_d;
        end
    end

    assign out_valid_o = valid_q;
    assign illegal_o   = illegal_q;
    assign result_o    = result_q;

endmodule

// File: rtl/bms_unit_chk.sv
module bms_unit_chk #(
    parameter  int LANES  = 8,
    localparam int DATA_W = 8 * LANES,
    localparam int OFS_W  = $clog2(LANES)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              in_valid_i,
    input logic [6:0]        func_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic              out_valid_o,
    input logic [DATA_W-1:0] result_o,
    input logic              illegal_o
);

    assert_valid_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o);

    assert_idle_drops_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> !out_valid_o);

    assert_hold_when_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> $stable(result_o));

    assert_illegal_gives_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> (out_valid_o && result_o == '0));

    assert_insert_high_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && (func_i inside {7'h57, 7'h67, 7'h77}) && b_i[OFS_W-1:0] == '0)
        |=> result_o == '0);

    assert_mask_high_passes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && (func_i inside {7'h52, 7'h62, 7'h72}) && b_i[OFS_W-1:0] == '0)
        |=> result_o == $past(a_i));

    assert_zap_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && func_i == 7'h30 && b_i[LANES-1:0] == '1) |=> result_o == '0);

endmodule

bind bms_unit bms_unit_chk #(.LANES(LANES)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .func_i      (func_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .out_valid_o (out_valid_o),
    .result_o    (result_o),
    .illegal_o   (illegal_o)
);

// File: tb/bms_unit_tb.sv
`timescale 1ns/1ps
module bms_unit_tb;

    localparam int LANES = 8;
    localparam int DW    = 8 * LANES;
    localparam int NV    = 32;
    localparam logic [63:0] AX = 64'h0123456789ABCDEF;
    localparam logic [63:0] AS = 64'h8000000000000000;

    typedef struct packed {
        logic [6:0]  fn;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
        logic        bad;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VT [NV] = '{
        '{7'h39, AX, 64'd4,     64'h123456789ABCDEF0, 1'b0, 8'd1},  // R1 sll
        '{7'h34, AX, 64'd8,     64'h000123456789ABCD, 1'b0, 8'd1},  // R1 srl
        '{7'h3c, AS, 64'h44,    64'hF800000000000000, 1'b0, 8'd1},  // R1 sra, B[6] ignored
        '{7'h34, AS, 64'd63,    64'h0000000000000001, 1'b0, 8'd1},  // R1 srl max
        '{7'h12, AX, 64'd3,     64'h0123450000ABCDEF, 1'b0, 8'd2},  // R2 word
        '{7'h32, AX, 64'd6,     64'h0000456789ABCDEF, 1'b0, 8'd2},  // R2 quad, cut at 63
        '{7'h02, AX, 64'd0,     64'h0123456789ABCD00, 1'b0, 8'd2},  // R2 byte
        '{7'h22, AX, 64'd6,     64'h0000456789ABCDEF, 1'b0, 8'd2},  // R2 long, cut
        '{7'h52, AX, 64'd0,     AX,                   1'b0, 8'd3},  // R3 offset 0
        '{7'h52, AX, 64'd7,     64'h0123456789ABCD00, 1'b0, 8'd3},  // R3 word
        '{7'h72, AX, 64'd3,     64'h0123456789000000, 1'b0, 8'd3},  // R3 quad
        '{7'h62, AX, 64'd6,     64'h0123456789AB0000, 1'b0, 8'd3},  // R3 long
        '{7'h06, AX, 64'd5,     64'h0000000000000045, 1'b0, 8'd4},  // R4 byte
        '{7'h26, AX, 64'd2,     64'h00000000456789AB, 1'b0, 8'd4},  // R4 long
        '{7'h36, AX, 64'd7,     64'h0000000000000001, 1'b0, 8'd4},  // R4 quad
        '{7'h16, AX, 64'd6,     64'h0000000000000123, 1'b0, 8'd4},  // R4 word
        '{7'h5a, AX, 64'd0,     64'h000000000000CDEF, 1'b0, 8'd5},  // R5 offset 0
        '{7'h6a, AX, 64'd6,     64'h00000000CDEF0000, 1'b0, 8'd5},  // R5 long
        '{7'h7a, AX, 64'd3,     64'hABCDEF0000000000, 1'b0, 8'd5},  // R5 quad
        '{7'h0b, AX, 64'd2,     64'h0000000000EF0000, 1'b0, 8'd6},  // R6 byte
        '{7'h1b, AX, 64'd7,     64'hEF00000000000000, 1'b0, 8'd6},  // R6 word, cut
        '{7'h3b, AX, 64'd1,     64'h23456789ABCDEF00, 1'b0, 8'd6},  // R6 quad
        '{7'h2b, AX, 64'd4,     64'h89ABCDEF00000000, 1'b0, 8'd6},  // R6 long
        '{7'h57, AX, 64'd7,     64'h00000000000000CD, 1'b0, 8'd7},  // R7 word
        '{7'h57, AX, 64'd0,     64'h0000000000000000, 1'b0, 8'd7},  // R7 offset 0
        '{7'h77, AX, 64'd1,     64'h0000000000000001, 1'b0, 8'd7},  // R7 quad
        '{7'h67, AX, 64'd5,     64'h0000000000000089, 1'b0, 8'd7},  // R7 long
        '{7'h30, AX, 64'h0F,    64'h0123456700000000, 1'b0, 8'd8},  // R8 zap
        '{7'h31, AX, 64'h0F,    64'h0000000089ABCDEF, 1'b0, 8'd8},  // R8 zap-not
        '{7'h30, AX, 64'h1FF,   64'h0000000000000000, 1'b0, 8'd8},  // R8 bit 8 ignored
        '{7'h00, AX, 64'd3,     64'h0000000000000000, 1'b1, 8'd10}, // R10 unlisted
        '{7'h39, AX, 64'd0,     AX,                   1'b0, 8'd1}   // R1 zero amount
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [6:0]    func = '0;
    logic [DW-1:0] a = '0;
    logic [DW-1:0] b = '0;
    logic          out_valid;
    logic [DW-1:0] result;
    logic          illegal;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    bms_unit #(.LANES(LANES)) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .in_valid_i  (in_valid),
        .func_i      (func),
        .a_i         (a),
        .b_i         (b),
        .out_valid_o (out_valid),
        .result_o    (result),
        .illegal_o   (illegal)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset result", result, '0);
        check("R11 reset valid", 64'(out_valid), 64'd0);
        check("R11 reset illegal", 64'(illegal), 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            in_valid = 1'b1;
            func     = VT[i].fn;
            a        = VT[i].a;
            b        = VT[i].b;
            @(negedge clk);
            check($sformatf("R%0d vector %0d result", VT[i].req, i), result, VT[i].exp);
            check($sformatf("R10 vector %0d illegal", i), 64'(illegal), 64'(VT[i].bad));
            check($sformatf("R9 vector %0d valid", i), 64'(out_valid), 64'd1);
        end

        // R12: idle cycles with changing operands leave the result alone
        in_valid = 1'b0;
        func     = 7'h30;
        a        = 64'hFFFF_0000_FFFF_0000;
        b        = 64'h00;
        @(negedge clk);
        check("R9 idle valid", 64'(out_valid), 64'd0);
        check("R12 idle result", result, AX);
        func = 7'h3b;
        b    = 64'd3;
        @(negedge clk);
        check("R12 idle result second", result, AX);
        check("R10 idle illegal", 64'(illegal), 64'd0);

        // R10: another unlisted code, then recovery on a legal code
        in_valid = 1'b1;
        func     = 7'h7f;
        a        = AX;
        b        = 64'd1;
        @(negedge clk);
        check("R10 code 0x7f result", result, '0);
        check("R10 code 0x7f illegal", 64'(illegal), 64'd1);
        func = 7'h31;
        b    = 64'hFF;
        @(negedge clk);
        check("R8 zap-not all kept", result, AX);
        check("R10 illegal cleared", 64'(illegal), 64'd0);

        // R11: reset after traffic
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        check("R11 mid-run reset result", result, '0);
        check("R11 mid-run reset valid", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule